// File: doc/BRIEF.md
# Memory Interrupt Report Scanner

This block is the host-side consumer of interrupt reports that hardware units leave in memory instead of in registers. Each unit owns one source byte, and a 16-byte status region in which every byte stands for one interrupt bit. A set byte normally reads 0xFF. When the host interrupt line pulses, the scanner walks a fixed list of units. For every unit whose source byte is nonzero, it clears that byte and reads the one status byte of interest. If that byte is nonzero, it clears it too and issues a dispatch pulse carrying the unit and bit index.

Engine units are listed by parameter and each is tested on status bit 0. Two controller units follow the engines, each at its own fixed index and each tested on one message bit. The second controller is visited only when its presence input is high. A byte that is nonzero but not 0xFF still counts as set, but the scanner also raises an error pulse. Memory is reached through a byte read port with a request/valid handshake and a byte write port with a request/acknowledge handshake.

Top module: `irq_report_scanner`

## Requirements
- R1: After reset the scanner is idle: no read or write request, no dispatch and no error pulse.
- R2: While `scan_en` is low, a trigger starts no scan and causes no memory access; report bytes stay as they are.
- R3: A unit's source byte is read at SRC_BASE (default 0x400) + unit index. A zero byte causes no status access for that unit. A nonzero byte is written back as 0x00.
- R4: The status byte read for a unit is at STS_BASE (default 0x000) + unit*16 + bit. The bit is ENG_BIT (default 0) for engines and CTL_BIT (default 15) for both controllers.
- R5: A nonzero status byte is written back as 0x00 and then produces exactly one single-cycle `disp_valid` pulse with that unit and bit. A zero status byte produces no dispatch.
- R6: A nonzero byte other than 0xFF, whether in a source or a status byte, is treated as set and raises a one-cycle `err_pulse`.
- R7: Units are visited in the order of the engine list (default units 0, 4, 12), then controller 0 (default unit 25), then controller 1 (default unit 26). Controller 1 is visited only when `ctl1_present` is high.
- R8: Triggers that arrive during a scan are merged into one pending request. That request starts exactly one further full scan after the current one ends.
- R9: `rd_req` and `rd_addr` stay stable until `rd_valid`. `wr_req`, `wr_addr` and `wr_data` (0x00) stay stable until `wr_ack`. Read and write requests are never raised together.
- R10: Other bytes of a unit's status region are never read or written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 1 | Host interrupt pulse that requests a scan |
| scan_en | input | 1 | Report buffer configured and scanning enabled |
| ctl1_present | input | 1 | Second controller unit exists |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | ADDR_W | Byte read address |
| rd_valid | input | 1 | Read data valid; ends the read |
| rd_data | input | 8 | Read data byte |
| wr_req | output | 1 | Byte write request |
| wr_addr | output | ADDR_W | Byte write address |
| wr_data | output | 8 | Write data byte (always 0x00) |
| wr_ack | input | 1 | Write accepted; ends the write |
| disp_valid | output | 1 | One-cycle dispatch pulse |
| disp_unit | output | UNIT_W | Unit index of the dispatch |
| disp_bit | output | 4 | Bit index of the dispatch |
| err_pulse | output | 1 | Report byte was nonzero but not 0xFF |

## Verification
A wrong slot counter or a wrong address computation shows up at once as a read of an address outside the expected set. It also shows up as a dispatch with the wrong unit, or in the wrong order, when the scan ends. A lost pending flag shows up only after the scan finishes, as a missing second read of the first source byte. A state machine that fails to clear a byte leaves 0xFF in the bench memory, which the checks read after the port goes quiet. The handshake properties catch a dropped or moving request within one cycle.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_SRC_RD = 3'd1,
    S_SRC_WR = 3'd2,
    S_STS_RD = 3'd3,
    S_STS_WR = 3'd4,
    S_NEXT   = 3'd5
  } scan_st_t;

  localparam int unsigned REGION_BYTES = 16;

  // byte address of a unit's source byte
  function automatic int unsigned src_byte(int unsigned base, int unsigned unit);
    return base + unit;
  endfunction

  // byte address of one bit inside a unit's status region
  function automatic int unsigned sts_byte(int unsigned base, int unsigned unit,
                                           int unsigned bitn);
    return base + unit * REGION_BYTES + bitn;
  endfunction

  function automatic logic byte_is_set(logic [7:0] v);
    return v != 8'h00;
  endfunction

  function automatic logic byte_is_odd(logic [7:0] v);
    return (v != 8'h00) && (v != 8'hFF);
  endfunction

endpackage

// File: rtl/irqs_slot_map.sv
module irqs_slot_map #(
  parameter int unsigned NUM_ENG = 3,
  parameter int unsigned UNIT_W  = 6,
  parameter logic [NUM_ENG*UNIT_W-1:0] ENG_LIST = {6'd12, 6'd4, 6'd0},
  parameter int unsigned CTL0_IDX = 25,
  parameter int unsigned CTL1_IDX = 26,
  parameter int unsigned ENG_BIT  = 0,
  parameter int unsigned CTL_BIT  = 15,
  localparam int unsigned SLOTS   = NUM_ENG + 2,
  localparam int unsigned SLOT_W  = $clog2(SLOTS)
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic              ctl1_present,
  output logic [UNIT_W-1:0] unit,
  output logic [3:0]        bitn,
  output logic              last
);

  logic [UNIT_W-1:0] tbl_unit [SLOTS];
  logic [3:0]        tbl_bit  [SLOTS];

  genvar g;
  generate
    for (g = 0; g < NUM_ENG; g++) begin : g_eng
      assign tbl_unit[g] = ENG_LIST[g*UNIT_W +: UNIT_W];
      assign tbl_bit[g]  = 4'(ENG_BIT);
    end
  endgenerate

  assign tbl_unit[NUM_ENG]   = UNIT_W'(CTL0_IDX);
  assign tbl_bit[NUM_ENG]    = 4'(CTL_BIT);
  assign tbl_unit[NUM_ENG+1] = UNIT_W'(CTL1_IDX);
  assign tbl_bit[NUM_ENG+1]  = 4'(CTL_BIT);

  always_comb begin
    unit = '0;
    bitn = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (slot == SLOT_W'(i)) begin
        unit = tbl_unit[i];
        bitn = tbl_bit[i];
      end
    end
  end

  assign last = ctl1_present ? (slot == SLOT_W'(NUM_ENG + 1))
                             : (slot == SLOT_W'(NUM_ENG));

endmodule

// File: rtl/irqs_byte_check.sv
module irqs_byte_check
  import irqs_pkg::*;
(
  input  logic [7:0] value,
  output logic       is_set,
  output logic       is_odd
);
  assign is_set = byte_is_set(value);
  assign is_odd = byte_is_odd(value);
endmodule

// File: rtl/irq_report_scanner.sv
module irq_report_scanner
  import irqs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned UNIT_W   = 6,
  parameter int unsigned NUM_ENG  = 3,
  parameter logic [NUM_ENG*UNIT_W-1:0] ENG_LIST = {6'd12, 6'd4, 6'd0},
  parameter int unsigned CTL0_IDX = 25,
  parameter int unsigned CTL1_IDX = 26,
  parameter int unsigned ENG_BIT  = 0,
  parameter int unsigned CTL_BIT  = 15,
  parameter int unsigned STS_BASE = 'h000,
  parameter int unsigned SRC_BASE = 'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic              scan_en,
  input  logic              ctl1_present,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  input  logic              wr_ack,
  output logic              disp_valid,
  output logic [UNIT_W-1:0] disp_unit,
  output logic [3:0]        disp_bit,
  output logic              err_pulse
);

  localparam int unsigned SLOT_W = $clog2(NUM_ENG + 2);

  scan_st_t          state;
  logic [SLOT_W-1:0] slot;
  logic              pend;

  // named internal events
  logic              start;
  logic              rd_done;
  logic              wr_done;
  logic              byte_set;
  logic              byte_odd;
  logic              slot_last;
  logic [UNIT_W-1:0] cur_unit;
  logic [3:0]        cur_bit;
  logic [ADDR_W-1:0] src_addr;
  logic [ADDR_W-1:0] sts_addr;

  irqs_slot_map #(
    .NUM_ENG (NUM_ENG), .UNIT_W(UNIT_W), .ENG_LIST(ENG_LIST),
    .CTL0_IDX(CTL0_IDX), .CTL1_IDX(CTL1_IDX),
    .ENG_BIT (ENG_BIT),  .CTL_BIT (CTL_BIT)
  ) i_map (
    .slot(slot), .ctl1_present(ctl1_present),
    .unit(cur_unit), .bitn(cur_bit), .last(slot_last)
  );

  irqs_byte_check i_chk (.value(rd_data), .is_set(byte_set), .is_odd(byte_odd));

  assign src_addr = ADDR_W'(src_byte(SRC_BASE, int'(cur_unit)));
  assign sts_addr = ADDR_W'(sts_byte(STS_BASE, int'(cur_unit), int'(cur_bit)));

  assign rd_req  = (state == S_SRC_RD) || (state == S_STS_RD);
  assign wr_req  = (state == S_SRC_WR) || (state == S_STS_WR);
  assign rd_addr = (state == S_STS_RD) ? sts_addr : src_addr;
  assign wr_addr = (state == S_STS_WR) ? sts_addr : src_addr;
  assign wr_data = 8'h00;

  assign rd_done = rd_req && rd_valid;
  assign wr_done = wr_req && wr_ack;
  assign start   = (state == S_IDLE) && scan_en && (trig_in || pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (!scan_en || start) begin
      pend <= 1'b0;
    end else if (trig_in) begin
      pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      slot  <= '0;
    end else begin
      case (state)
        S_IDLE:   if (start) begin
                    state <= S_SRC_RD;
                    slot  <= '0;
                  end
        S_SRC_RD: if (rd_done) state <= byte_set ? S_SRC_WR : S_NEXT;
        S_SRC_WR: if (wr_done) state <= S_STS_RD;
        S_STS_RD: if (rd_done) state <= byte_set ? S_STS_WR : S_NEXT;
        S_STS_WR: if (wr_done) state <= S_NEXT;
        S_NEXT:   if (slot_last) begin
                    state <= S_IDLE;
                  end else begin
                    state <= S_SRC_RD;
                    slot  <= slot + 1'b1;
                  end
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_valid <= 1'b0;
      disp_unit  <= '0;
      disp_bit   <= '0;
      err_pulse  <= 1'b0;
    end else begin
      disp_valid <= (state == S_STS_WR) && wr_ack;
      if ((state == S_STS_WR) && wr_ack) begin
        disp_unit <= cur_unit;
        disp_bit  <= cur_bit;
      end
      err_pulse <= rd_done && byte_odd;
    end
  end

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req)); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr)); // R9
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && wr_data == 8'h00); // R9
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) && !scan_en |=> (state == S_IDLE) && !rd_req && !wr_req); // R2
  AST_DISP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> $past(wr_ack) && !$past(rd_req)); // R5
  AST_DISP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> !disp_valid); // R5
  AST_ERR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(rd_valid) && $past(rd_req)); // R6
  AST_SCAN_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) && (state == S_SRC_RD) && (slot == '0) |-> $past(scan_en)); // R8

endmodule

// File: tb/test_irq_report_scanner.sv
`timescale 1ns/1ps
module test_irq_report_scanner;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_in = 1'b0;
  logic        scan_en = 1'b0;
  logic        ctl1_present = 1'b0;
  logic        rd_req, wr_req;
  logic [10:0] rd_addr, wr_addr;
  logic        rd_valid = 1'b0;
  logic [7:0]  rd_data = 8'h00;
  logic [7:0]  wr_data;
  logic        wr_ack = 1'b0;
  logic        disp_valid, err_pulse;
  logic [5:0]  disp_unit;
  logic [3:0]  disp_bit;

  always #2.5 clk = ~clk;

  irq_report_scanner i_irq_report_scanner (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .scan_en(scan_en),
    .ctl1_present(ctl1_present),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .disp_valid(disp_valid), .disp_unit(disp_unit), .disp_bit(disp_bit),
    .err_pulse(err_pulse)
  );

  logic [7:0] mem [0:2047];
  int lat = 0, rcnt = 0;
  int n_rd = 0, n_wr = 0, n_src0 = 0, n_err = 0, n_disp = 0;
  int log_unit [0:15];
  int log_bit  [0:15];
  int n_cmp = 0, n_bad = 0;

  // memory model
  always @(posedge clk) begin
    if (rd_valid) rd_valid <= 1'b0;
    else if (rd_req) begin
      if (rcnt >= lat) begin
        rd_valid <= 1'b1;
        rd_data  <= mem[rd_addr];
        rcnt     <= 0;
        n_rd = n_rd + 1;
        if (rd_addr == 11'h400) n_src0 = n_src0 + 1;
      end else rcnt <= rcnt + 1;
    end
    if (wr_ack) wr_ack <= 1'b0;
    else if (wr_req) begin
      mem[wr_addr] <= wr_data;
      wr_ack <= 1'b1;
      n_wr = n_wr + 1;
    end
    if (disp_valid) begin
      if (n_disp < 16) begin
        log_unit[n_disp] = int'(disp_unit);
        log_bit[n_disp]  = int'(disp_bit);
      end
      n_disp = n_disp + 1;
    end
    if (err_pulse) n_err = n_err + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  function automatic int src_a(int u); return 'h400 + u; endfunction
  function automatic int sts_a(int u, int b); return u * 16 + b; endfunction

  task automatic clear_all();
    for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
    n_rd = 0; n_wr = 0; n_src0 = 0; n_err = 0; n_disp = 0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_in = 1'b1;
    @(negedge clk); trig_in = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    int guard = 0;
    while (q < 30 && guard < 5000) begin
      @(negedge clk);
      if (rd_req || wr_req) q = 0; else q++;
      guard++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk_eq("R1 rd_req after reset", int'(rd_req), 0);
    chk_eq("R1 wr_req after reset", int'(wr_req), 0);
    chk_eq("R1 disp_valid after reset", int'(disp_valid), 0);
    chk_eq("R1 err_pulse after reset", int'(err_pulse), 0);
  endtask

  task automatic t_disabled();
    clear_all();
    scan_en = 1'b0;
    mem[src_a(4)] = 8'hFF; mem[sts_a(4, 0)] = 8'hFF;
    pulse_trig();
    wait_quiet();
    chk_eq("R2 no reads while disabled", n_rd, 0);
    chk_eq("R2 no writes while disabled", n_wr, 0);
    chk_eq("R2 source byte kept", int'(mem[src_a(4)]), 'hFF);
    chk_eq("R2 no dispatch", n_disp, 0);
    // enabling afterwards must not replay the dropped trigger
    scan_en = 1'b1;
    wait_quiet();
    chk_eq("R2 trigger not retained", n_rd, 0);
  endtask

  task automatic t_single_engine();
    clear_all();
    lat = 2;
    mem[src_a(4)] = 8'hFF; mem[sts_a(4, 0)] = 8'hFF; mem[sts_a(4, 3)] = 8'hFF;
    pulse_trig();
    wait_quiet();
    chk_eq("R5 one dispatch", n_disp, 1);
    chk_eq("R4 dispatch unit", log_unit[0], 4);
    chk_eq("R4 dispatch bit", log_bit[0], 0);
    chk_eq("R3 source cleared", int'(mem[src_a(4)]), 0);
    chk_eq("R5 status cleared", int'(mem[sts_a(4, 0)]), 0);
    chk_eq("R10 other status byte untouched", int'(mem[sts_a(4, 3)]), 'hFF);
    // 4 source reads + 1 status read; 2 writes
    chk_eq("R3 read count", n_rd, 5);
    chk_eq("R3 write count", n_wr, 2);
    chk_eq("R6 no error on 0xFF", n_err, 0);
  endtask

  task automatic t_src_only();
    clear_all();
    lat = 0;
    mem[src_a(12)] = 8'hFF;
    pulse_trig();
    wait_quiet();
    chk_eq("R5 zero status gives no dispatch", n_disp, 0);
    chk_eq("R3 source cleared without status hit", int'(mem[src_a(12)]), 0);
    chk_eq("R3 writes: source only", n_wr, 1);
  endtask

  task automatic t_order();
    clear_all();
    lat = 1;
    ctl1_present = 1'b0;
    mem[src_a(0)]  = 8'hFF; mem[sts_a(0, 0)]   = 8'hFF;
    mem[src_a(12)] = 8'hFF; mem[sts_a(12, 0)]  = 8'hFF;
    mem[src_a(25)] = 8'hFF; mem[sts_a(25, 15)] = 8'hFF;
    mem[src_a(26)] = 8'hFF; mem[sts_a(26, 15)] = 8'hFF;
    pulse_trig();
    wait_quiet();
    chk_eq("R7 dispatch count without ctl1", n_disp, 3);
    chk_eq("R7 first unit", log_unit[0], 0);
    chk_eq("R7 second unit", log_unit[1], 12);
    chk_eq("R7 third unit (ctl0)", log_unit[2], 25);
    chk_eq("R4 ctl0 bit", log_bit[2], 15);
    chk_eq("R7 ctl1 skipped", int'(mem[src_a(26)]), 'hFF);
    n_disp = 0;
    ctl1_present = 1'b1;
    pulse_trig();
    wait_quiet();
    chk_eq("R7 ctl1 visited when present", n_disp, 1);
    chk_eq("R7 ctl1 unit", log_unit[0], 26);
    chk_eq("R4 ctl1 bit", log_bit[0], 15);
    ctl1_present = 1'b0;
  endtask

  task automatic t_odd_values();
    clear_all();
    lat = 0;
    mem[src_a(0)] = 8'h01; mem[sts_a(0, 0)] = 8'h80;
    pulse_trig();
    wait_quiet();
    chk_eq("R6 odd bytes still dispatch", n_disp, 1);
    chk_eq("R6 error pulses", n_err, 2);
    chk_eq("R6 odd status cleared", int'(mem[sts_a(0, 0)]), 0);
  endtask

  task automatic t_rescan();
    clear_all();
    lat = 3;
    pulse_trig();
    @(negedge clk);
    trig_in = 1'b1; @(negedge clk); trig_in = 1'b0;
    @(negedge clk);
    trig_in = 1'b1; @(negedge clk); trig_in = 1'b0;
    wait_quiet();
    chk_eq("R8 exactly one rescan", n_src0, 2);
    chk_eq("R8 total source reads", n_rd, 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin log_unit[i] = -1; log_bit[i] = -1; end
    clear_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_single_engine();
    t_src_only();
    t_order();
    t_odd_values();
    t_rescan();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule